// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address. It keeps a small set of recent page translations. Each 32-bit address is split into a 20-bit virtual page number and a 12-bit in-page offset, which means 4 KB pages. The offset is passed through to the physical address without change. Only the page number is translated.

On each accepted lookup, the page number is compared against the tag of every valid slot in the same cycle. On a hit, the stored frame number is joined with the offset, and the result is returned one cycle later. On a miss, the block raises a walk request that carries the page number to an external page-table walker. It then stalls new lookups until the walker returns a frame on the refill port.

The refilled translation goes into the lowest-numbered empty slot. If no slot is empty, it replaces the least recently used slot. A single-cycle flush pulse invalidates every slot.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, `rsp_valid` and `walk_req` are 0 and `lk_ready` is 1. Every slot is invalid, so the first lookup of any page misses.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both 1. If its page number (`lk_vaddr[31:12]`) matches a valid slot, `rsp_valid` is 1 in the next cycle. `rsp_paddr[31:12]` then holds that slot's frame.
- R3: `rsp_paddr[11:0]` always equals bits [11:0] of the virtual address that produced the response, for both hits and refills.
- R4: When an accepted lookup misses, `walk_req` is 1 from the next cycle on, with `walk_vpn` equal to `lk_vaddr[31:12]`. Both stay stable until `fill_valid` is seen, and `lk_ready` is 0 for that whole time.
- R5: A cycle with `fill_valid` high while `walk_req` is high ends the walk. In the next cycle, `rsp_valid` is 1, `walk_req` is 0, and `rsp_paddr` equals {`fill_frame`, pending offset}.
- R6: A refilled translation is installed, so a later lookup of the same page hits and returns the refilled frame.
- R7: A refill uses an empty slot whenever one exists. After a flush, 32 refills of distinct pages all stay resident.
- R8: When all slots are valid, a refill replaces the slot that was least recently hit or installed. Both hits and installs count as uses.
- R9: While `flush` is 1, `lk_ready` is 0. In the following cycle, every slot is invalid, and earlier translations miss.
- R10: `rsp_valid` is 1 only in the cycle after an accepted hit or after a refill that ends a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Translated address valid (one cycle per request) |
| rsp_paddr | output | 32 | Physical address: frame in [31:12], offset in [11:0] |
| walk_req | output | 1 | Miss pending, page-table walk requested |
| walk_vpn | output | 20 | Page number to be walked |
| fill_valid | input | 1 | Walker returns a frame |
| fill_frame | input | 20 | Frame number returned by the walker |
| flush | input | 1 | Invalidate all slots |

## Verification
A table of mixed misses and hits is run first. It uses offsets at 0x000, 0xFFF and in between, and page numbers at both extremes. This separates offset pass-through from frame selection, and a hit from a spurious walk.

Next, a flush is followed by 32 fresh pages and then a pass that re-reads all of them. Every slot must be filled before any eviction, so this pass tells empty-slot preference apart from early replacement.

Finally, one old page is re-touched before a new page is brought in. Which page then misses, and which still hit, shows whether eviction follows recency or slot index. A miss left unanswered for several cycles shows that the walk request and the stall are held.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/xlat_cam.sv
`timescale 1ns/1ps
// Parallel tag compare over all slots; lowest matching index wins.
module xlat_cam #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 20,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [TAG_W-1:0]   slot_tag [ENTRIES],
  input  logic [TAG_W-1:0]   key,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = slot_valid[g] && (slot_tag[g] == key);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_lru.sv
`timescale 1ns/1ps
// Age ranking: ages always form a permutation of 0..ENTRIES-1.
// Age 0 is most recent, ENTRIES-1 is the replacement victim.
module xlat_lru #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)  age_d[i] = '0;
        else if (age_q[i] < ref_age) age_d[i] = age_q[i] + IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age_q[g] <= IDX_W'(g);
      else if (touch_en) age_q[g] <= age_d[g];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_alloc.sv
`timescale 1ns/1ps
// Refill slot choice: lowest empty slot, else the age-ranked victim.
module xlat_alloc #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [IDX_W-1:0]   victim_idx,
  output logic [IDX_W-1:0]   fill_idx
);
  always_comb begin
    fill_idx = victim_idx;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) fill_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer #(
  parameter int VA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 20,
  parameter int ENTRIES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  output logic                     lk_ready,
  output logic                     rsp_valid,
  output logic [FRAME_W+OFS_W-1:0] rsp_paddr,
  output logic                     walk_req,
  output logic [VA_W-OFS_W-1:0]    walk_vpn,
  input  logic                     fill_valid,
  input  logic [FRAME_W-1:0]       fill_frame,
  input  logic                     flush
);
  import xlat_pkg::*;

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PA_W  = FRAME_W + OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // slot storage
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  // control state
  xlat_state_e       state_q, state_d;
  logic [VPN_W-1:0]  pend_vpn_q;
  logic [OFS_W-1:0]  pend_ofs_q;
  logic              pend_en;
  logic              rsp_v_d;
  logic [PA_W-1:0]   rsp_pa_d;
  logic              rsp_pa_en;

  // lookup / replacement signals
  logic [VPN_W-1:0]  lk_vpn;
  logic [OFS_W-1:0]  lk_ofs;
  logic              accept;
  logic              cam_hit;
  logic [IDX_W-1:0]  cam_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [IDX_W-1:0]  fill_idx;
  logic              install;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFS_W];
  assign lk_ofs   = lk_vaddr[OFS_W-1:0];
  assign lk_ready = (state_q == ST_IDLE) && !flush;
  assign accept   = lk_valid && lk_ready;
  assign walk_req = (state_q == ST_WALK);
  assign walk_vpn = pend_vpn_q;

  xlat_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_cam (
    .slot_valid (valid_q),
    .slot_tag   (tag_q),
    .key        (lk_vpn),
    .hit        (cam_hit),
    .hit_idx    (cam_idx)
  );

  xlat_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  xlat_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
    .slot_valid (valid_q),
    .victim_idx (victim_idx),
    .fill_idx   (fill_idx)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pend_en   = 1'b0;
    rsp_v_d   = 1'b0;
    rsp_pa_d  = rsp_paddr;
    rsp_pa_en = 1'b0;
    install   = 1'b0;
    touch_en  = 1'b0;
    touch_idx = cam_idx;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cam_hit) begin
            rsp_v_d   = 1'b1;
            rsp_pa_d  = {frame_q[cam_idx], lk_ofs};
            rsp_pa_en = 1'b1;
            touch_en  = 1'b1;
          end else begin
            pend_en = 1'b1;
            state_d = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (fill_valid) begin
          install   = 1'b1;
          touch_en  = 1'b1;
          touch_idx = fill_idx;
          rsp_v_d   = 1'b1;
          rsp_pa_d  = {fill_frame, pend_ofs_q};
          rsp_pa_en = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    valid_d = valid_q;
    if (install) valid_d[fill_idx] = 1'b1;
    if (flush)   valid_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      valid_q   <= '0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      valid_q   <= valid_d;
      rsp_valid <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vpn_q <= '0;
      pend_ofs_q <= '0;
      rsp_paddr  <= '0;
    end else begin
      if (pend_en) begin
        pend_vpn_q <= lk_vpn;
        pend_ofs_q <= lk_ofs;
      end
      if (rsp_pa_en) rsp_paddr <= rsp_pa_d;
    end
  end

  // slot payload: no reset, written only on install
  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[fill_idx]   <= pend_vpn_q;
      frame_q[fill_idx] <= fill_frame;
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk #(
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 20,
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic                     lk_ready,
  input logic                     rsp_valid,
  input logic [FRAME_W+OFS_W-1:0] rsp_paddr,
  input logic                     walk_req,
  input logic [VPN_W-1:0]         walk_vpn,
  input logic                     fill_valid,
  input logic [FRAME_W-1:0]       fill_frame,
  input logic                     flush,
  input logic [ENTRIES-1:0]       valid_vec,
  input logic                     touch_en,
  input logic [IDX_W-1:0]         touch_idx,
  input logic [IDX_W-1:0]         victim_idx
);
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !lk_ready);

  p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn)));

  p_fill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid) |=>
      (rsp_valid && !walk_req && rsp_paddr[FRAME_W+OFS_W-1:OFS_W] == $past(fill_frame)));

  p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> ($past(lk_valid && lk_ready) || $past(walk_req && fill_valid)));

  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lk_ready);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  p_victim_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (victim_idx != $past(touch_idx)));
endmodule

bind xlat_buffer xlat_buffer_chk #(
  .OFS_W(OFS_W), .FRAME_W(FRAME_W), .VPN_W(VPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .rsp_valid  (rsp_valid),
  .rsp_paddr  (rsp_paddr),
  .walk_req   (walk_req),
  .walk_vpn   (walk_vpn),
  .fill_valid (fill_valid),
  .fill_frame (fill_frame),
  .flush      (flush),
  .valid_vec  (valid_q),
  .touch_en   (touch_en),
  .touch_idx  (touch_idx),
  .victim_idx (victim_idx)
);

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
module xlat_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 32;
  localparam int NVEC       = 9;

  // vector: {vaddr[31:0], expect_hit, frame[19:0]}; expected paddr = {frame, vaddr[11:0]}
  localparam logic [52:0] VEC [NVEC] = '{
    {32'h0001_0123, 1'b0, 20'hAAAAA},
    {32'h0001_0FFF, 1'b1, 20'hAAAAA},
    {32'h0002_0000, 1'b0, 20'h12345},
    {32'h0001_0000, 1'b1, 20'hAAAAA},
    {32'hFFFF_FABC, 1'b0, 20'h00001},
    {32'h0002_07FF, 1'b1, 20'h12345},
    {32'hFFFF_F001, 1'b1, 20'h00001},
    {32'h0000_0000, 1'b0, 20'hFFFFF},
    {32'h0000_0FFF, 1'b1, 20'hFFFFF}
  };

  logic        clk, rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        fill_valid;
  logic [19:0] fill_frame;
  logic        flush;

  int total = 0;
  int bad   = 0;

  xlat_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid),
    .fill_frame(fill_frame), .flush(flush)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one lookup; answers a walk with fr if one appears
  task automatic lookup(input logic [31:0] va, input bit exp_hit, input logic [19:0] fr, input string req);
    logic [31:0] exp_pa;
    bit got_hit;
    exp_pa = {fr, va[11:0]};
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    got_hit  = rsp_valid;
    if (walk_req) begin
      chk(walk_vpn == va[31:12], {req, " R4 walk page"}, 64'(walk_vpn), 64'(va[31:12]));
      chk(!lk_ready, {req, " R4 stall"}, 64'(lk_ready), 64'd0);
      fill_valid = 1'b1;
      fill_frame = fr;
      @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid && !walk_req, {req, " R5 walk end"}, {62'd0, rsp_valid, walk_req}, 64'd2);
      chk(rsp_paddr == exp_pa, {req, " R5 R3 refill addr"}, 64'(rsp_paddr), 64'(exp_pa));
    end else if (got_hit) begin
      chk(rsp_paddr == exp_pa, {req, " R2 R3 hit addr"}, 64'(rsp_paddr), 64'(exp_pa));
    end
    chk(got_hit == exp_hit, {req, " R2 hit/miss"}, 64'(got_hit), 64'(exp_hit));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
    fill_valid = 1'b0; fill_frame = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!rsp_valid && !walk_req && lk_ready, "R1 reset outputs",
        {61'd0, rsp_valid, walk_req, lk_ready}, 64'd1);

    // table walk: R1 (first lookup misses), R2, R3, R6
    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][52:21], VEC[i][20], VEC[i][19:0], "R6 table");
    end

    // R4: unanswered miss holds request and stall
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = 32'h0ABC_D5A5;
    @(negedge clk);
    lk_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(walk_req && walk_vpn == 20'h0ABCD && !lk_ready && !rsp_valid, "R4 hold",
          {43'd0, walk_req, walk_vpn}, {43'd0, 1'b1, 20'h0ABCD});
      @(negedge clk);
    end
    fill_valid = 1'b1;
    fill_frame = 20'h55555;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == 32'h5555_55A5, "R5 late refill", 64'(rsp_paddr), 64'h5555_55A5);
    @(negedge clk);
    chk(!rsp_valid, "R10 single response", 64'(rsp_valid), 64'd0);

    // R9 flush
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!lk_ready, "R9 ready low during flush", 64'(lk_ready), 64'd0);
    @(negedge clk);
    flush = 1'b0;
    lookup(32'h0001_0123, 1'b0, 20'hBBBBB, "R9 after flush");
    lookup(32'h0002_0456, 1'b0, 20'h22222, "R9 after flush");

    // R7: flush, then 32 distinct pages all resident
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      lookup({20'h00100 + 20'(i), 12'h010}, 1'b0, 20'h00200 + 20'(i), "R7 fill");
    for (int i = 0; i < NSLOT; i++)
      lookup({20'h00100 + 20'(i), 12'hF0F}, 1'b1, 20'h00200 + 20'(i), "R7 resident");

    // R8: recency order is 0x100..0x11F; re-touch 0x100, so 0x101 becomes the victim
    lookup(32'h0010_0000, 1'b1, 20'h00200, "R8 touch");
    lookup(32'h0030_0ABC, 1'b0, 20'h0ABCD, "R8 new page");
    lookup(32'h0010_1000, 1'b0, 20'h00301, "R8 evicted page");
    lookup(32'h0010_0001, 1'b1, 20'h00200, "R8 kept page");
    lookup(32'h0030_0002, 1'b1, 20'h0ABCD, "R8 new resident");
    lookup(32'h0010_3003, 1'b1, 20'h00203, "R8 other resident");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule